// File: doc/BRIEF.md
# Pipelined Radix-4 Booth Signed Multiplier

This block multiplies two 16-bit two's complement operands and returns the exact 32-bit signed product. Once the pipeline is full it accepts a new operand pair on every clock and returns one product per clock. A result appears a fixed three cycles after its operands were presented.

The multiplier operand is recoded into eight radix-4 digits in the range -2 to +2. Each digit picks a multiple of the multiplicand, and these multiples form eight sign-extended rows. The rows, together with one vector of +1 corrections for the negated rows, go into a carry-save tree of 3:2 compressors. The tree leaves one sum row and one carry row, which are registered. A single plain addition of those two rows then forms the registered product.

A valid flag travels alongside the data. Pipeline registers load only when the data they receive is valid, so between results the product output holds its last value. A synchronous reset clears every valid flag and throws away any operation still in flight. It does not touch the data registers.

Top module: `booth_pipe_mul`

## Requirements
- R1: `product` equals the exact 32-bit two's complement value of `opA * opB` for every operand pair. This includes 0x8000 × 0x8000 = 0x40000000, 0x7FFF × 0x8000 = 0xC0008000, and any product with a zero operand, which gives 0.
- R2: `outValid` is high exactly when `inValid` was high three rising edges earlier. The `product` shown with it belongs to the operands sampled at that same edge.
- R3: Operands presented with `inValid` high on consecutive cycles give results on consecutive cycles, in the same order, with no stall.
- R4: While `rst` is high at a rising edge, all valid flags are cleared and `outValid` is low after that edge. Operations in flight at that edge never produce `outValid`.
- R5: Multiplier bits (b[2i+1], b[2i], b[2i-1]) select digit i, with b[-1] taken as 0. The mapping is 000→0, 001→+1, 010→+1, 011→+2, 100→-2, 101→-1, 110→-1, 111→0. At most one of the ±1× and ±2× selections is active for a row, and row i carries weight 4^i.
- R6: A negative digit forms its row by inverting the selected multiple and adding a +1 correction at bit 2i. The registered rows plus the correction vector sum to the product modulo 2^32.
- R7: The carry-save reduction keeps the total. The registered sum row plus the registered carry row equals the total of the rows that fed it.
- R8: While no result is delivered (`outValid` low), `product` keeps the value of the last delivered result. A reset does not change it.
- R9: Cycles with `inValid` low produce no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, clears the valid pipeline |
| inValid | input | 1 | Operand pair on `opA`/`opB` is to be multiplied |
| opA | input | 16 | Multiplicand, two's complement |
| opB | input | 16 | Multiplier (the recoded operand), two's complement |
| outValid | output | 1 | `product` holds a new result this cycle |
| product | output | 32 | Two's complement product |

## Verification
The multiplier is driven with a full cross of the corner values 0, ±1, 0x7FFF, 0x8000 and 0x5555. These separate sign-extension and most-negative-operand faults from plain arithmetic faults. Periodic multiplier patterns such as 0xAAAA, 0x3333, 0xCCCC, 0xFFFE and 0x6666 force every Booth digit code, in particular both −2 and the 111 group, onto many rows at once. A bad digit table or a missing negation correction then shows up as a wrong product. A long back-to-back random stream tests throughput and ordering. Sparse and alternating valid patterns, and a reset issued with operations in flight, separate a correct valid pipeline and output hold from ones that leak, drop or shift results.

// File: rtl/mul_pkg.sv
package mul_pkg;

  // Load strobes from control to datapath, one per pipeline register bank
  typedef struct packed {
    logic ldPp;    // partial product rows
    logic ldCs;    // carry-save sum/carry rows
    logic ldProd;  // final product
  } stageStrobe_t;

  // Rows left after a given number of 3:2 compression layers
  function automatic int rowsAfter(input int rows, input int layers);
    int n;
    n = rows;
    for (int k = 0; k < layers; k++) n = n - n / 3;
    return n;
  endfunction

  // Number of 3:2 layers needed to reach two rows
  function automatic int treeLevels(input int rows);
    int n;
    int c;
    n = rows;
    c = 0;
    while (n > 2) begin
      n = n - n / 3;
      c++;
    end
    return c;
  endfunction

endpackage

// File: rtl/csa_row.sv
module csa_row #(
  parameter int W = 32
) (
  input  logic [W-1:0] inA,
  input  logic [W-1:0] inB,
  input  logic [W-1:0] inC,
  output logic [W-1:0] sumVec,
  output logic [W-1:0] carryVec
);

  logic [W-1:0] maj;

  for (genvar k = 0; k < W; k++) begin : g_bit
    assign sumVec[k] = inA[k] ^ inB[k] ^ inC[k];
    assign maj[k]    = (inA[k] & inB[k]) | (inC[k] & (inA[k] ^ inB[k]));
  end

  // carries move one place left; the top carry falls outside modulo 2^W
  assign carryVec = {maj[W-2:0], 1'b0};

endmodule

// File: rtl/csa_tree.sv
module csa_tree
  import mul_pkg::*;
#(
  parameter int W    = 32,
  parameter int ROWS = 9
) (
  input  logic [W-1:0] rowsIn [ROWS],
  output logic [W-1:0] sumOut,
  output logic [W-1:0] carryOut
);

  localparam int NLEV = treeLevels(ROWS);

  logic [W-1:0] lvl [NLEV+1][ROWS];

  for (genvar j = 0; j < ROWS; j++) begin : g_in
    assign lvl[0][j] = rowsIn[j];
  end

  for (genvar l = 0; l < NLEV; l++) begin : g_lvl
    localparam int CNT = rowsAfter(ROWS, l);
    localparam int GRP = CNT / 3;
    localparam int NXT = CNT - GRP;

    for (genvar g = 0; g < GRP; g++) begin : g_csa
      csa_row #(.W(W)) u_csa (
        .inA     (lvl[l][3*g]),
        .inB     (lvl[l][3*g+1]),
        .inC     (lvl[l][3*g+2]),
        .sumVec  (lvl[l+1][2*g]),
        .carryVec(lvl[l+1][2*g+1])
      );
    end

    for (genvar j = 2*GRP; j < ROWS; j++) begin : g_pass
      if (j < NXT) begin : g_keep
        assign lvl[l+1][j] = lvl[l][j+GRP];
      end else begin : g_zero
        assign lvl[l+1][j] = '0;
      end
    end
  end

  assign sumOut   = lvl[NLEV][0];
  assign carryOut = lvl[NLEV][1];

endmodule

// File: rtl/booth_pp_gen.sv
module booth_pp_gen #(
  parameter int OP_W   = 16,
  parameter int PROD_W = 2 * OP_W,
  parameter int NUM_PP = OP_W / 2
) (
  input  logic [OP_W-1:0]   mcand,
  input  logic [OP_W-1:0]   mplier,
  output logic [PROD_W-1:0] rows [NUM_PP+1]
);

  logic [NUM_PP-1:0] negV;

  for (genvar i = 0; i < NUM_PP; i++) begin : g_row
    logic ySel2, ySel1, ySel0;
    logic selOne, selTwo, selNeg;
    logic [OP_W:0] multiple;
    logic [OP_W:0] field;

    assign ySel2 = mplier[2*i+1];
    assign ySel1 = mplier[2*i];
    if (i == 0) begin : g_low
      assign ySel0 = 1'b0;
    end else begin : g_up
      assign ySel0 = mplier[2*i-1];
    end

    assign selOne = ySel1 ^ ySel0;
    assign selTwo = (ySel2 & ~ySel1 & ~ySel0) | (~ySel2 & ySel1 & ySel0);
    assign selNeg = ySel2 & ~(ySel1 & ySel0);

    always_comb begin
      if (selOne)      multiple = {mcand[OP_W-1], mcand};
      else if (selTwo) multiple = {mcand, 1'b0};
      else             multiple = '0;
    end

    assign field   = selNeg ? ~multiple : multiple;
    assign negV[i] = selNeg;
    assign rows[i] = {{(PROD_W-OP_W-1){field[OP_W]}}, field} << (2*i);

    // R5: a digit selects at most one magnitude; 000 and 111 select none
    always_comb begin
      p_digit_excl_r5: assert ($onehot0({selOne, selTwo}));
      if ({ySel2, ySel1, ySel0} == 3'b111 || {ySel2, ySel1, ySel0} == 3'b000)
        p_digit_zero_r5: assert (!selOne && !selTwo);
    end
  end

  // +1 corrections for negated rows, one at each row's lowest bit
  always_comb begin
    rows[NUM_PP] = '0;
    for (int i = 0; i < NUM_PP; i++) rows[NUM_PP][2*i] = negV[i];
  end

endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  output stageStrobe_t strb,
  output logic         outValid
);

  localparam int LAT = 3;

  logic [LAT-1:0] validPipe;
  logic [1:0]     sinceReset;

  always_ff @(posedge clk) begin
    if (rst) validPipe <= '0;
    else     validPipe <= {validPipe[LAT-2:0], inValid};
  end

  always_comb begin
    strb.ldPp   = inValid      & ~rst;
    strb.ldCs   = validPipe[0] & ~rst;
    strb.ldProd = validPipe[1] & ~rst;
  end

  assign outValid = validPipe[LAT-1];

  always_ff @(posedge clk) begin
    if (rst)                     sinceReset <= '0;
    else if (sinceReset != 2'd3) sinceReset <= sinceReset + 2'd1;
  end

  // R4: reset leaves no valid result behind
  p_reset_clear_r4: assert property (@(posedge clk) rst |=> !outValid);

  // R2: output valid is input valid three edges later
  p_valid_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (sinceReset == 2'd3) |-> (outValid == $past(inValid, 3)));

endmodule

// File: rtl/mul_datapath.sv
module mul_datapath
  import mul_pkg::*;
#(
  parameter int OP_W   = 16,
  parameter int PROD_W = 2 * OP_W,
  parameter int NUM_PP = OP_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  stageStrobe_t      strb,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  output logic [PROD_W-1:0] product
);

  localparam int NROWS = NUM_PP + 1;

  logic [PROD_W-1:0] ppRows [NROWS];
  logic [PROD_W-1:0] ppQ    [NROWS];
  logic [PROD_W-1:0] treeSum, treeCarry;
  logic [PROD_W-1:0] sumQ, carryQ;
  logic [PROD_W-1:0] prodQ;

  booth_pp_gen #(.OP_W(OP_W), .PROD_W(PROD_W), .NUM_PP(NUM_PP)) u_pp (
    .mcand (opA),
    .mplier(opB),
    .rows  (ppRows)
  );

  always_ff @(posedge clk) begin
    if (strb.ldPp) begin
      for (int k = 0; k < NROWS; k++) ppQ[k] <= ppRows[k];
    end
  end

  csa_tree #(.W(PROD_W), .ROWS(NROWS)) u_tree (
    .rowsIn  (ppQ),
    .sumOut  (treeSum),
    .carryOut(treeCarry)
  );

  always_ff @(posedge clk) begin
    if (strb.ldCs) begin
      sumQ   <= treeSum;
      carryQ <= treeCarry;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.ldProd) prodQ <= sumQ + carryQ;
  end

  assign product = prodQ;

  // Reference values used only by the assertions below
  logic [PROD_W-1:0] ppTotal;
  logic [PROD_W-1:0] aExt, bExt, refProd;

  always_comb begin
    ppTotal = '0;
    for (int k = 0; k < NROWS; k++) ppTotal = ppTotal + ppQ[k];
  end

  assign aExt    = {{(PROD_W-OP_W){opA[OP_W-1]}}, opA};
  assign bExt    = {{(PROD_W-OP_W){opB[OP_W-1]}}, opB};
  assign refProd = aExt * bExt;

  // R6: registered rows plus corrections total the signed product
  p_rows_total_r6: assert property (@(posedge clk) disable iff (rst)
    strb.ldPp |=> (ppTotal == $past(refProd)));

  // R7: carry-save pair keeps the total of the rows
  p_cs_keep_r7: assert property (@(posedge clk) disable iff (rst)
    strb.ldCs |=> ((sumQ + carryQ) == $past(ppTotal)));

  // R8: product holds when no result is loaded
  p_prod_hold_r8: assert property (@(posedge clk)
    !strb.ldProd |=> $stable(prodQ));

endmodule

// File: rtl/booth_pipe_mul.sv
module booth_pipe_mul
  import mul_pkg::*;
#(
  parameter int OP_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  input  logic [OP_W-1:0]     opA,
  input  logic [OP_W-1:0]     opB,
  output logic                outValid,
  output logic [2*OP_W-1:0]   product
);

  localparam int PROD_W = 2 * OP_W;
  localparam int NUM_PP = OP_W / 2;

  stageStrobe_t strb;

  mul_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .strb    (strb),
    .outValid(outValid)
  );

  mul_datapath #(.OP_W(OP_W), .PROD_W(PROD_W), .NUM_PP(NUM_PP)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .opA    (opA),
    .opB    (opB),
    .product(product)
  );

endmodule

// File: tb/sim_booth_pipe_mul.sv
module sim_booth_pipe_mul;

  localparam int W = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          inValid = 1'b0;
  logic [W-1:0]  opA = '0;
  logic [W-1:0]  opB = '0;
  logic          outValid;
  logic [2*W-1:0] product;

  always #5 clk = ~clk;

  booth_pipe_mul #(.OP_W(W)) u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .opA(opA), .opB(opB),
    .outValid(outValid), .product(product)
  );

  int nChk = 0;
  int nBad = 0;
  int cyc  = 0;

  // Model of the three-stage pipeline, built from R2
  bit          mv [3];
  logic [31:0] mp [3];
  string       mt [3];
  logic [31:0] lastP;
  bit          haveP = 0;
  string       idleTag = "R4";

  function automatic logic [31:0] refMul(input logic [15:0] a, input logic [15:0] b);
    logic [31:0] ea, eb;
    ea = {{16{a[15]}}, a};
    eb = {{16{b[15]}}, b};
    return ea * eb;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One cycle: check outputs, then drive the next inputs
  task automatic step(input bit v, input logic [15:0] a, input logic [15:0] b,
                      input string tag, input bit r = 1'b0);
    @(negedge clk);
    chk(mv[2] ? mt[2] : idleTag, {31'b0, outValid}, {31'b0, mv[2]});
    if (mv[2]) begin
      chk(mt[2], product, mp[2]);
      lastP = mp[2];
      haveP = 1;
    end else if (haveP) begin
      chk("R8", product, lastP);
    end
    rst = r; inValid = v; opA = a; opB = b;
    for (int k = 2; k > 0; k--) begin
      mv[k] = mv[k-1]; mp[k] = mp[k-1]; mt[k] = mt[k-1];
    end
    mv[0] = v & ~r; mp[0] = refMul(a, b); mt[0] = tag;
    if (r) for (int k = 0; k < 3; k++) mv[k] = 0;
  endtask

  task automatic drain(input string tag);
    idleTag = tag;
    for (int k = 0; k < 5; k++) step(0, 16'h0, 16'h0, tag);
  endtask

  task automatic tResetState();
    idleTag = "R4";
    for (int k = 0; k < 3; k++) step(0, 16'h0, 16'h0, "R4", 1'b1);
    step(0, 16'h0, 16'h0, "R4");
    step(0, 16'h0, 16'h0, "R4");
  endtask

  task automatic tCorners();
    logic [15:0] vals [6];
    vals = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h5555};
    idleTag = "R3";
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++)
        step(1, vals[i], vals[j], "R1");
    drain("R9");
    // explicit boundary values from R1
    chk("R1", refMul(16'h8000, 16'h8000), 32'h40000000);
    chk("R1", refMul(16'h7FFF, 16'h8000), 32'hC0008000);
  endtask

  task automatic tBoothDigits();
    logic [15:0] pats [8];
    logic [15:0] cands [3];
    pats  = '{16'hAAAA, 16'h3333, 16'hCCCC, 16'hFFFE, 16'h6666, 16'h9999, 16'h8001, 16'h4924};
    cands = '{16'h1234, 16'hB5C3, 16'h8000};
    idleTag = "R5";
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 3; j++)
        step(1, cands[j], pats[i], (pats[i][15] ? "R6" : "R5"));
    drain("R9");
  endtask

  task automatic tCarryHeavy();
    idleTag = "R7";
    step(1, 16'h7FFF, 16'h5555, "R7");
    step(1, 16'hFFFF, 16'hAAAA, "R7");
    step(1, 16'h8000, 16'h7FFF, "R7");
    step(1, 16'hFFFF, 16'hFFFF, "R7");
    drain("R9");
  endtask

  task automatic tRandomStream();
    idleTag = "R3";
    for (int k = 0; k < 300; k++)
      step(1, 16'($urandom), 16'($urandom), "R3");
    drain("R9");
  endtask

  task automatic tBubbles();
    idleTag = "R9";
    for (int k = 0; k < 40; k++)
      step(k[0], 16'($urandom), 16'($urandom), "R2");
    for (int k = 0; k < 60; k++)
      step(($urandom % 3) == 0, 16'($urandom), 16'($urandom), "R2");
    drain("R8");
  endtask

  task automatic tResetInFlight();
    idleTag = "R4";
    step(1, 16'h1357, 16'h2468, "R4");
    step(1, 16'hFEDC, 16'h0123, "R4");
    step(0, 16'h0, 16'h0, "R4", 1'b1);
    step(1, 16'h4444, 16'h4444, "R4", 1'b1);
    for (int k = 0; k < 5; k++) step(0, 16'h0, 16'h0, "R4");
    step(1, 16'h8000, 16'h8000, "R1");
    drain("R9");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog: actual %0d cycles expected under 50000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 3; k++) begin
      mv[k] = 0; mp[k] = '0; mt[k] = "R4";
    end
    tResetState();
    tCorners();
    tBoothDigits();
    tCarryHeavy();
    tRandomStream();
    tBubbles();
    tResetInFlight();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule